// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked host and an external byte-wide asynchronous static RAM with a 19-bit address and a shared data bus. The host raises a request with an address, a direction flag and write data, and holds it until a one-clock acknowledge comes back. For a read, the acknowledge also brings the returned byte. The controller latches the request and runs the RAM strobes (chip select, write strobe and output enable, all active low). It also drives a separate output word and a drive-enable for the shared data bus. The pad cell outside the block combines these into the bidirectional pins.

All strobe timing comes from cycle counters. Each minimum time in nanoseconds is turned into a cycle count with a ceiling division by the clock period parameter, and no count is less than one cycle. The write strobe alone closes each write. Output enable stays high for the whole write, so the RAM never drives the bus then. After every access the RAM is deselected for a turnaround gap, and that gap is long enough for the RAM's output drivers to release the bus before the controller can drive it. The figures below are for the default 8 ns clock.

Top module: `sram_access_ctrl`

## Requirements
- R1: While reset is low, and on leaving it, sramCeN, sramWeN and sramOeN are high and sramDqOe and reqAck are low.
- R2: A read (reqWrite = 0) holds sramCeN and sramOeN low with sramWeN high for ceil(55 ns / period) cycles (7 at 8 ns). The byte on sramDqIn at the last clock edge of that window appears on rdData, and it equals the RAM content at the requested address.
- R3: reqAck is high for exactly one clock, on the same edge that ends the access. For a read this is also the edge that captures the data. reqAck rises 7 clocks after sramCeN falls, for reads and for writes.
- R4: During a write sramOeN stays high. sramDqOe is high only while sramCeN is low in a write. sramWeN is low only while sramCeN is low, sramOeN is high and sramDqOe is high.
- R5: The write strobe stays low for at least ceil(45 ns / period) cycles (6). sramCeN stays low for at least ceil(55 ns / period) cycles (7) in a write. The byte presented on sramDqOut is stored at the latched address.
- R6: sramAddr, and sramDqOut while it is driven, do not change while sramCeN is low.
- R7: Between accesses sramCeN returns high for at least ceil(20 ns / period) cycles (3). sramDqOe never rises sooner than that many cycles after sramOeN has risen.
- R8: Changes on reqAddr, reqWdata and reqWrite after a request is accepted have no effect on the access that is running.
- R9: With reqValid low the controller stays idle, with sramCeN high and the bus not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Host request, held until reqAck |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 19 | Byte address |
| reqWdata | input | 8 | Byte to write |
| reqAck | output | 1 | One-clock completion pulse |
| rdData | output | 8 | Byte returned by the last read |
| sramAddr | output | 19 | RAM address bus |
| sramDqIn | input | 8 | Data arriving from the RAM bus |
| sramDqOut | output | 8 | Data to drive onto the RAM bus |
| sramDqOe | output | 1 | Drive enable for sramDqOut |
| sramCeN | output | 1 | RAM chip select, active low |
| sramWeN | output | 1 | RAM write strobe, active low |
| sramOeN | output | 1 | RAM output enable, active low |

## Verification
On one clock edge the controller captures the read byte and pulses reqAck. To test this, the bench RAM model returns the inverted byte until chip select and output enable have been low for the full access time. A capture one edge early therefore returns the wrong data. The bench checks that rdData is correct in the same cycle that reqAck is seen, and that reqAck lasted exactly one cycle. A second pair of events coincides at the end of a write: the write strobe rises, the bus drive ends and chip select rises. The bench model commits the write only when the strobe rises, and a monitor confirms that the data was still driven while the strobe was low.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WSETUP,
    ST_WPULSE,
    ST_STBY
  } ctrlState_t;

  // strobes from control to datapath/pins
  typedef struct packed {
    logic ceN;
    logic weN;
    logic oeN;
    logic drive;
    logic load;
    logic capture;
  } ctrlStrobes_t;

  // ceiling of ns / period, never below one cycle
  function automatic int unsigned nsToCycles(input int unsigned ns, input int unsigned periodNs);
    int unsigned c;
    c = (ns + periodNs - 1) / periodNs;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned RD_CYC   = 7,
  parameter int unsigned WS_CYC   = 1,
  parameter int unsigned WP_CYC   = 6,
  parameter int unsigned TURN_CYC = 3,
  parameter int unsigned CNT_W    = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqWrite,
  output ctrlStrobes_t stb,
  output logic         reqAck
);

  localparam logic [CNT_W-1:0] RD_LAST   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WS_LAST   = CNT_W'(WS_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LAST   = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] TURN_LAST = CNT_W'(TURN_CYC - 1);

  ctrlState_t       state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext, limit;
  logic             phaseLast;
  logic             ceNq, weNq, oeNq, driveQ;

  always_comb begin
    case (state)
      ST_READ:   limit = RD_LAST;
      ST_WSETUP: limit = WS_LAST;
      ST_WPULSE: limit = WP_LAST;
      ST_STBY:   limit = TURN_LAST;
      default:   limit = '0;
    endcase
  end

  assign phaseLast = (state != ST_IDLE) && (cnt == limit);

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:   if (reqValid) stateNext = reqWrite ? ST_WSETUP : ST_READ;
      ST_READ:   if (phaseLast) stateNext = ST_STBY;
      ST_WSETUP: if (phaseLast) stateNext = ST_WPULSE;
      ST_WPULSE: if (phaseLast) stateNext = ST_STBY;
      ST_STBY:   if (phaseLast) stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
    cntNext = (state == ST_IDLE || phaseLast) ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      ceNq   <= 1'b1;
      weNq   <= 1'b1;
      oeNq   <= 1'b1;
      driveQ <= 1'b0;
      reqAck <= 1'b0;
    end else begin
      state  <= stateNext;
      cnt    <= cntNext;
      // strobes registered from the next state: glitch-free at the pins
      ceNq   <= !(stateNext inside {ST_READ, ST_WSETUP, ST_WPULSE});
      oeNq   <= (stateNext != ST_READ);
      weNq   <= (stateNext != ST_WPULSE);
      driveQ <= (stateNext inside {ST_WSETUP, ST_WPULSE});
      reqAck <= phaseLast && (state == ST_READ || state == ST_WPULSE);
    end
  end

  always_comb begin
    stb.ceN     = ceNq;
    stb.weN     = weNq;
    stb.oeN     = oeNq;
    stb.drive   = driveQ;
    stb.load    = (state == ST_IDLE) && reqValid;
    stb.capture = phaseLast && (state == ST_READ);
  end

endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] dqIn,
  output logic [ADDR_W-1:0] addrQ,
  output logic [DATA_W-1:0] wdataQ,
  output logic [DATA_W-1:0] rdData
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdData <= '0;
    end else begin
      if (stb.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (stb.capture) rdData <= dqIn;
    end
  end

endmodule

// File: rtl/sram_access_ctrl.sv
module sram_access_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 19,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CLK_PERIOD_NS = 8,
  parameter int unsigned T_ACC_NS      = 55,
  parameter int unsigned T_OE_NS       = 25,
  parameter int unsigned T_WP_NS       = 45,
  parameter int unsigned T_WC_NS       = 55,
  parameter int unsigned T_DS_NS       = 25,
  parameter int unsigned T_HZ_NS       = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqAck,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] sramAddr,
  input  logic [DATA_W-1:0] sramDqIn,
  output logic [DATA_W-1:0] sramDqOut,
  output logic              sramDqOe,
  output logic              sramCeN,
  output logic              sramWeN,
  output logic              sramOeN
);

  // select and output enable fall together, so the slower path sets the read window
  localparam int unsigned RD_CYC   = nsToCycles((T_ACC_NS > T_OE_NS) ? T_ACC_NS : T_OE_NS, CLK_PERIOD_NS);
  localparam int unsigned WP_CYC   = nsToCycles((T_WP_NS > T_DS_NS) ? T_WP_NS : T_DS_NS, CLK_PERIOD_NS);
  localparam int unsigned WC_CYC   = nsToCycles(T_WC_NS, CLK_PERIOD_NS);
  localparam int unsigned WS_CYC   = (WC_CYC > WP_CYC) ? (WC_CYC - WP_CYC) : 1;
  localparam int unsigned TURN_CYC = nsToCycles(T_HZ_NS, CLK_PERIOD_NS);
  localparam int unsigned MAX_A    = (RD_CYC > WP_CYC) ? RD_CYC : WP_CYC;
  localparam int unsigned MAX_B    = (WS_CYC > TURN_CYC) ? WS_CYC : TURN_CYC;
  localparam int unsigned MAX_CYC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);

  ctrlStrobes_t stb;

  sram_ctrl_fsm #(
    .RD_CYC  (RD_CYC),
    .WS_CYC  (WS_CYC),
    .WP_CYC  (WP_CYC),
    .TURN_CYC(TURN_CYC),
    .CNT_W   (CNT_W)
  ) i_fsm (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .stb     (stb),
    .reqAck  (reqAck)
  );

  sram_ctrl_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .dqIn    (sramDqIn),
    .addrQ   (sramAddr),
    .wdataQ  (sramDqOut),
    .rdData  (rdData)
  );

  assign sramCeN  = stb.ceN;
  assign sramWeN  = stb.weN;
  assign sramOeN  = stb.oeN;
  assign sramDqOe = stb.drive;

endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 19,
  parameter int unsigned CLK_PERIOD_NS = 8,
  parameter int unsigned T_WP_NS       = 45,
  parameter int unsigned T_HZ_NS       = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqAck,
  input logic [ADDR_W-1:0] sramAddr,
  input logic              sramDqOe,
  input logic              sramCeN,
  input logic              sramWeN,
  input logic              sramOeN
);

  localparam int unsigned WP_MIN   = nsToCycles(T_WP_NS, CLK_PERIOD_NS);
  localparam int unsigned TURN_MIN = nsToCycles(T_HZ_NS, CLK_PERIOD_NS);

  logic [15:0] weLowCnt, oeHighCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weLowCnt  <= '0;
      oeHighCnt <= '1;
    end else begin
      weLowCnt  <= sramWeN ? '0 : ((weLowCnt == '1) ? weLowCnt : weLowCnt + 1'b1);
      oeHighCnt <= !sramOeN ? '0 : ((oeHighCnt == '1) ? oeHighCnt : oeHighCnt + 1'b1);
    end
  end

  AST_READ_STROBES: assert property (@(posedge clk) disable iff (!rstN)
    !sramOeN |-> !sramCeN && sramWeN); // R2
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |=> !reqAck); // R3
  AST_ACK_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramCeN) |-> reqAck); // R3
  AST_DRIVE_SAFE: assert property (@(posedge clk) disable iff (!rstN)
    sramDqOe |-> sramOeN && !sramCeN); // R4
  AST_WE_ENVELOPE: assert property (@(posedge clk) disable iff (!rstN)
    !sramWeN |-> !sramCeN && sramOeN && sramDqOe); // R4
  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramWeN) |-> weLowCnt >= 16'(WP_MIN)); // R5
  AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    !sramCeN && $past(!sramCeN) |-> $stable(sramAddr)); // R6
  AST_BUS_TURN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramDqOe) |-> oeHighCnt >= 16'(TURN_MIN)); // R7

endmodule

bind sram_access_ctrl sram_ctrl_checker #(
  .ADDR_W       (ADDR_W),
  .CLK_PERIOD_NS(CLK_PERIOD_NS),
  .T_WP_NS      (T_WP_NS),
  .T_HZ_NS      (T_HZ_NS)
) i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .reqAck  (reqAck),
  .sramAddr(sramAddr),
  .sramDqOe(sramDqOe),
  .sramCeN (sramCeN),
  .sramWeN (sramWeN),
  .sramOeN (sramOeN)
);

// File: tb/test_sram_access_ctrl.sv
`timescale 1ns/1ps
module test_sram_access_ctrl;

  localparam int PERIOD   = 8;
  localparam int RD_EXP   = (55 + PERIOD - 1) / PERIOD;
  localparam int WP_EXP   = (45 + PERIOD - 1) / PERIOD;
  localparam int WC_EXP   = (55 + PERIOD - 1) / PERIOD;
  localparam int TURN_EXP = (20 + PERIOD - 1) / PERIOD;
  localparam int WR_LAT   = (WC_EXP > WP_EXP + 1) ? WC_EXP : WP_EXP + 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [18:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        reqAck;
  logic [7:0]  rdData;
  logic [18:0] sramAddr;
  logic [7:0]  sramDqIn;
  logic [7:0]  sramDqOut;
  logic        sramDqOe, sramCeN, sramWeN, sramOeN;

  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  sram_access_ctrl i_sram_access_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqAck(reqAck), .rdData(rdData),
    .sramAddr(sramAddr), .sramDqIn(sramDqIn), .sramDqOut(sramDqOut),
    .sramDqOe(sramDqOe), .sramCeN(sramCeN), .sramWeN(sramWeN), .sramOeN(sramOeN)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // RAM model and bus monitor, evaluated at falling edges
  logic [7:0] ramMem [int unsigned];
  logic [7:0] shadow [int unsigned];

  function automatic logic [7:0] seedByte(input logic [18:0] a);
    return 8'(a * 3) ^ 8'(a >> 7) ^ 8'(a >> 13);
  endfunction
  function automatic logic [7:0] ramRead(input logic [18:0] a);
    return ramMem.exists(32'(a)) ? ramMem[32'(a)] : seedByte(a);
  endfunction
  function automatic logic [7:0] expRead(input logic [18:0] a);
    return shadow.exists(32'(a)) ? shadow[32'(a)] : seedByte(a);
  endfunction

  int rdLow = 0, weLow = 0, ceLow = 0, ceHigh = 1000, oeHigh = 1000;
  bit inWrite = 0, prevDqOe = 0;
  logic [18:0] prevAddr = '0, pendAddr = '0;
  logic [7:0]  prevDout = '0, pendData = '0;

  always @(negedge clk) begin
    if (!rstN) begin
      sramDqIn = 8'h00;
      rdLow = 0; weLow = 0; ceLow = 0; ceHigh = 1000; oeHigh = 1000; prevDqOe = 0;
    end else begin
      // read data valid only once the access time has elapsed
      if (!sramCeN && !sramOeN) begin
        rdLow++;
        sramDqIn = (rdLow * PERIOD >= 55) ? ramRead(sramAddr) : ~ramRead(sramAddr);
      end else begin
        rdLow = 0;
        sramDqIn = 8'h00;
      end
      // write strobe
      if (!sramWeN) begin
        weLow++;
        pendAddr = sramAddr;
        pendData = sramDqOut;
        chk(!sramCeN && sramOeN && sramDqOe, "R4 write strobe envelope",
            {sramCeN, sramOeN, sramDqOe}, 3'b011);
      end else if (weLow > 0) begin
        chk(weLow >= WP_EXP, "R5 write strobe width", weLow, WP_EXP);
        ramMem[32'(pendAddr)] = pendData;
        weLow = 0;
      end
      if (sramDqOe) chk(sramOeN && !sramCeN, "R4 drive only with output disabled",
                        {sramOeN, sramCeN}, 2'b10);
      // bus turnaround
      if (sramDqOe && !prevDqOe) chk(oeHigh >= TURN_EXP, "R7 bus turnaround", oeHigh, TURN_EXP);
      prevDqOe = sramDqOe;
      oeHigh = sramOeN ? oeHigh + 1 : 0;
      // select window
      if (!sramCeN) begin
        if (ceLow == 0) begin
          chk(ceHigh >= TURN_EXP, "R7 deselect gap", ceHigh, TURN_EXP);
          inWrite = sramDqOe;
        end else begin
          chk(sramAddr == prevAddr, "R6 address stable", sramAddr, prevAddr);
          if (sramDqOe) chk(sramDqOut == prevDout, "R6 write data stable", sramDqOut, prevDout);
        end
        ceLow++;
        ceHigh = 0;
      end else begin
        if (ceLow > 0 && inWrite) chk(ceLow >= WC_EXP, "R5 write cycle length", ceLow, WC_EXP);
        ceLow = 0;
        ceHigh++;
      end
      prevAddr = sramAddr;
      prevDout = sramDqOut;
    end
  end

  // one host access; disturb changes the request lines after acceptance
  task automatic access(input bit wr, input logic [18:0] a, input logic [7:0] d,
                        input bit disturb, output logic [7:0] got);
    int n;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    do @(negedge clk); while (sramCeN);
    chk(sramAddr == a, "R8 latched address", sramAddr, a);
    if (disturb) begin
      reqAddr = ~a; reqWdata = ~d; reqWrite = !wr;
    end
    n = 0;
    do begin @(negedge clk); n++; end while (!reqAck && n < 40);
    chk(n == (wr ? WR_LAT : RD_EXP), "R3 acknowledge latency", n, wr ? WR_LAT : RD_EXP);
    got = rdData;
    reqValid = 1'b0;
    if (wr) shadow[32'(a)] = d;
    @(negedge clk);
    chk(!reqAck, "R3 acknowledge single cycle", reqAck, 0);
  endtask

  task automatic doRead(input logic [18:0] a, input bit disturb, input string tag);
    logic [7:0] got;
    access(1'b0, a, 8'h00, disturb, got);
    chk(got == expRead(a), tag, got, expRead(a));
  endtask

  initial begin
    logic [7:0] dummy;
    repeat (4) @(negedge clk);
    chk({sramCeN, sramWeN, sramOeN, sramDqOe, reqAck} == 5'b11100, "R1 reset state",
        {sramCeN, sramWeN, sramOeN, sramDqOe, reqAck}, 5'b11100);
    rstN = 1'b1;
    @(negedge clk);
    chk({sramCeN, sramWeN, sramOeN, sramDqOe, reqAck} == 5'b11100, "R1 after reset",
        {sramCeN, sramWeN, sramOeN, sramDqOe, reqAck}, 5'b11100);

    // R9: no request, no activity
    begin
      bit quiet = 1;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (!sramCeN || sramDqOe) quiet = 0;
      end
      chk(quiet, "R9 idle stays deselected", quiet, 1);
    end

    // R5: walking-one address sweep with arithmetic data
    for (int b = 0; b < 19; b++) access(1'b1, 19'(1) << b, 8'(b * 29 + 3), 1'b0, dummy);
    access(1'b1, 19'h00000, 8'hA5, 1'b0, dummy);
    access(1'b1, 19'h7FFFF, 8'h5A, 1'b0, dummy);

    // R2: read back the sweep
    for (int b = 0; b < 19; b++) doRead(19'(1) << b, 1'b0, "R2 read back walking address");
    doRead(19'h00000, 1'b0, "R2 read back low corner");
    doRead(19'h7FFFF, 1'b0, "R2 read back high corner");
    doRead(19'h12345, 1'b0, "R2 read untouched location");

    // R7: alternating write/read turnarounds
    for (int k = 0; k < 8; k++) begin
      access(1'b1, 19'h00040 + 19'(k), 8'(k * 53 + 17), 1'b0, dummy);
      doRead(19'h00040 + 19'(k), 1'b0, "R2 R7 read after write");
    end

    // R8: request lines disturbed during an access
    access(1'b1, 19'h05555, 8'h3C, 1'b1, dummy);
    doRead(19'h05555, 1'b0, "R8 write kept original address and data");
    doRead(~19'h05555, 1'b0, "R8 inverted address untouched");
    doRead(19'h00001, 1'b1, "R8 read kept original address");

    repeat (6) @(negedge clk);
    chk(sramCeN && !sramDqOe, "R9 idle after traffic", {sramCeN, sramDqOe}, 2'b10);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule